// File: doc/BRIEF.md
# Legacy/Corrected Address Sequencer

This block generates the bus cycles for three memory access kinds of an 8-bit processor datapath. The kinds are an indirect jump through a 16-bit pointer, an indexed read, and a read-modify-write. One mode bit selects between two behaviours. Legacy mode keeps the historical quirks: the pointer high byte wraps within its page, a page-crossing index reads a garbage address first, and a read-modify-write writes twice. Corrected mode repairs each of these, which costs one cycle or changes one bus cycle.

An operation is launched with a one-clock `start`, along with the kind, the mode, the operand address, the address of the last instruction byte and the index value. The block accepts the request only while idle. From the next clock it presents one bus cycle per clock on `bus_valid`/`bus_addr`/`bus_write`/`bus_wdata`, and it takes read data combinationally on `rdata`. For a read-modify-write, the captured value appears on `rmw_operand`, and the caller returns the modified byte on `rmw_result` in the same clock. `ready` low holds a read cycle. `done` is high during the final bus cycle, on the clock it completes, and `done_addr` then carries the jump target or the effective address.

Top module: `quirk_addr_seq`

## Requirements
- R1: After reset `busy`, `bus_valid` and `done` are low.
- R2: Indirect jump (kind 0), legacy mode (`fixed_mode`=0): the low byte is read at pointer P, and the high byte at {P[15:8], P[7:0]+1}, so the carry never leaves the page. The operation takes 2 clocks.
- R3: Indirect jump, corrected mode (`fixed_mode`=1): the high byte is read at P+1. When P[7:0]=FF, one clock with `bus_valid` low is inserted between the two reads (3 clocks total); otherwise the operation takes 2 clocks.
- R4: Indexed read (kind 1) whose sum operand+index stays in the operand's page does one read at that sum and takes 1 clock in either mode.
- R5: Legacy indexed read that crosses a page first reads {operand[15:8], sum[7:0]}, then reads the full sum (2 clocks).
- R6: Corrected indexed read that crosses a page first reads `last_pc`, then reads the full sum (2 clocks).
- R7: Legacy read-modify-write (kind 2) at the operand address does a read, then a write of the value read, then a write of `rmw_result` (3 clocks).
- R8: Corrected read-modify-write does a read, a second read of the same address, then one write of `rmw_result` (3 clocks).
- R9: While `ready` is low, a read cycle stays presented with the same address and the sequence does not advance.
- R10: In legacy mode, write cycles complete regardless of `ready`. In corrected mode, a write cycle is held while `ready` is low.
- R11: `done` is high for exactly the clock in which the final bus cycle completes. `done_addr` is then {high byte, low byte} for a jump, or the full effective address otherwise.
- R12: `start` raised while an operation is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch request, accepted when idle |
| kind | input | 2 | 0 indirect jump, 1 indexed read, 2 read-modify-write |
| fixed_mode | input | 1 | 0 legacy, 1 corrected |
| opnd | input | 16 | Pointer, base or target address |
| last_pc | input | 16 | Address of the last instruction byte |
| index | input | 8 | Index register value |
| ready | input | 1 | Bus ready; low stalls reads (and corrected writes) |
| rdata | input | 8 | Read data for the current cycle |
| rmw_result | input | 8 | Modified byte from the caller |
| bus_valid | output | 1 | A bus cycle is presented |
| bus_addr | output | 16 | Bus cycle address |
| bus_write | output | 1 | 1 for a write cycle |
| bus_wdata | output | 8 | Write data |
| rmw_operand | output | 8 | Byte captured by the read-modify-write read |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Final cycle completes this clock |
| done_addr | output | 16 | Jump target or effective address |

## Verification
The assertions assume two things about the caller. First, `rdata` is a stable function of `bus_addr` within a clock. Second, `ready` never stays low forever during a cycle that waits on it. The stimulus meets both: the memory model derives each byte from its address, and stalls come from a free-running pseudo-random pattern. The one directed case that ties `ready` low during writes is run only in legacy mode, where writes do not wait. Kind code 3 is never driven.

// File: rtl/qas_pkg.sv
package qas_pkg;
  localparam int AW     = 16;
  localparam int DW     = 8;
  localparam int PW     = 8;
  localparam int STEP_W = 2;

  typedef enum logic [1:0] {K_JMP = 2'd0, K_IDX = 2'd1, K_RMW = 2'd2, K_NONE = 2'd3} kind_e;

  typedef struct packed {
    logic          vld;
    logic          wr;
    logic          wnew;
    logic          last;
    logic          cap_lo;
    logic          cap_rd;
    logic [AW-1:0] addr;
  } cyc_t;

  // next byte inside the same page: carry discarded
  function automatic logic [AW-1:0] in_page_next(input logic [AW-1:0] p);
    logic [PW-1:0] lo;
    lo = p[PW-1:0] + 1'b1;
    return {p[AW-1:PW], lo};
  endfunction

  // base plus index without carry into the page number
  function automatic logic [AW-1:0] uncarried_sum(input logic [AW-1:0] b, input logic [DW-1:0] x);
    logic [PW-1:0] lo;
    lo = b[PW-1:0] + x;
    return {b[AW-1:PW], lo};
  endfunction

  function automatic logic [AW-1:0] full_sum(input logic [AW-1:0] b, input logic [DW-1:0] x);
    return b + AW'(x);
  endfunction
endpackage

// File: rtl/qas_cycle_plan.sv
module qas_cycle_plan
  import qas_pkg::*;
(
  input  kind_e              kind,
  input  logic               fixed,
  input  logic [STEP_W-1:0]  step,
  input  logic [AW-1:0]      ptr,
  input  logic [AW-1:0]      lpc,
  input  logic [DW-1:0]      idx,
  output cyc_t               cyc,
  output logic [AW-1:0]      ea
);
  logic [AW-1:0] ptr_wrap, ptr_inc, ea_raw;
  logic          ptr_cross, idx_cross;

  assign ptr_wrap  = in_page_next(ptr);
  assign ptr_inc   = ptr + 1'b1;
  assign ptr_cross = &ptr[PW-1:0];
  assign ea_raw    = uncarried_sum(ptr, idx);
  assign ea        = (kind == K_IDX) ? full_sum(ptr, idx) : ptr;
  assign idx_cross = (ea_raw != ea);

  always_comb begin
    cyc = '0;
    case (kind)
      K_JMP: begin
        case (step)
          2'd0: begin cyc.vld = 1'b1; cyc.addr = ptr; cyc.cap_lo = 1'b1; end
          2'd1: begin
            if (!fixed) begin
              cyc.vld = 1'b1; cyc.addr = ptr_wrap; cyc.last = 1'b1;
            end else if (!ptr_cross) begin
              cyc.vld = 1'b1; cyc.addr = ptr_inc; cyc.last = 1'b1;
            end
            // corrected and crossing: internal carry clock, no bus cycle
          end
          2'd2: begin cyc.vld = 1'b1; cyc.addr = ptr_inc; cyc.last = 1'b1; end
          default: cyc.last = 1'b1;
        endcase
      end
      K_IDX: begin
        case (step)
          2'd0: begin
            cyc.vld = 1'b1;
            if (!idx_cross) begin
              cyc.addr = ea; cyc.last = 1'b1;
            end else begin
              cyc.addr = fixed ? lpc : ea_raw;
            end
          end
          2'd1: begin cyc.vld = 1'b1; cyc.addr = ea; cyc.last = 1'b1; end
          default: cyc.last = 1'b1;
        endcase
      end
      K_RMW: begin
        case (step)
          2'd0: begin cyc.vld = 1'b1; cyc.addr = ptr; cyc.cap_rd = 1'b1; end
          2'd1: begin cyc.vld = 1'b1; cyc.addr = ptr; cyc.wr = !fixed; end
          2'd2: begin
            cyc.vld = 1'b1; cyc.addr = ptr; cyc.wr = 1'b1;
            cyc.wnew = 1'b1; cyc.last = 1'b1;
          end
          default: cyc.last = 1'b1;
        endcase
      end
      default: cyc.last = 1'b1;
    endcase
  end
endmodule

// File: rtl/qas_stepper.sv
module qas_stepper
  import qas_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         kind_in,
  input  logic               fixed_in,
  input  logic [AW-1:0]      opnd_in,
  input  logic [AW-1:0]      lpc_in,
  input  logic [DW-1:0]      idx_in,
  input  logic               ready,
  input  logic [DW-1:0]      rdata,
  input  cyc_t               cyc,
  output logic               busy,
  output logic               advance,
  output kind_e              kind_q,
  output logic               fixed_q,
  output logic [AW-1:0]      ptr_q,
  output logic [AW-1:0]      lpc_q,
  output logic [DW-1:0]      idx_q,
  output logic [STEP_W-1:0]  step_q,
  output logic [DW-1:0]      lo_q,
  output logic [DW-1:0]      rd_q
);
  logic cyc_ok;

  // a read waits for ready; a write waits only in corrected mode
  assign cyc_ok  = cyc.wr ? (!fixed_q || ready) : ready;
  assign advance = busy && (!cyc.vld || cyc_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      kind_q  <= K_NONE;
      fixed_q <= 1'b0;
      ptr_q   <= '0;
      lpc_q   <= '0;
      idx_q   <= '0;
      step_q  <= '0;
      lo_q    <= '0;
      rd_q    <= '0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        kind_q  <= kind_e'(kind_in);
        fixed_q <= fixed_in;
        ptr_q   <= opnd_in;
        lpc_q   <= lpc_in;
        idx_q   <= idx_in;
        step_q  <= '0;
      end
    end else if (advance) begin
      if (cyc.cap_lo) lo_q <= rdata;
      if (cyc.cap_rd) rd_q <= rdata;
      if (cyc.last) busy <= 1'b0;
      else          step_q <= step_q + 1'b1;
    end
  end

  a_r12_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(ptr_q) && $stable(kind_q) && $stable(fixed_q));

  a_r9_read_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cyc.vld && !cyc.wr && !ready |=> busy && $stable(step_q));

  a_r10_legacy_write_moves: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cyc.vld && cyc.wr && !fixed_q && !cyc.last |=> busy && step_q == $past(step_q) + 1'b1);

  a_r10_fixed_write_waits: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cyc.vld && cyc.wr && fixed_q && !ready |=> busy && $stable(step_q));
endmodule

// File: rtl/quirk_addr_seq.sv
module quirk_addr_seq
  import qas_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    kind,
  input  logic          fixed_mode,
  input  logic [15:0]   opnd,
  input  logic [15:0]   last_pc,
  input  logic [7:0]    index,
  input  logic          ready,
  input  logic [7:0]    rdata,
  input  logic [7:0]    rmw_result,
  output logic          bus_valid,
  output logic [15:0]   bus_addr,
  output logic          bus_write,
  output logic [7:0]    bus_wdata,
  output logic [7:0]    rmw_operand,
  output logic          busy,
  output logic          done,
  output logic [15:0]   done_addr
);
  cyc_t              cyc;
  kind_e             kind_q;
  logic              fixed_q, advance;
  logic [AW-1:0]     ptr_q, lpc_q, ea;
  logic [DW-1:0]     idx_q, lo_q, rd_q;
  logic [STEP_W-1:0] step_q;

  qas_cycle_plan u_plan (
    .kind (kind_q), .fixed (fixed_q), .step (step_q), .ptr (ptr_q),
    .lpc (lpc_q), .idx (idx_q), .cyc (cyc), .ea (ea)
  );

  qas_stepper u_step (
    .clk (clk), .rst_n (rst_n), .start (start), .kind_in (kind),
    .fixed_in (fixed_mode), .opnd_in (opnd), .lpc_in (last_pc), .idx_in (index),
    .ready (ready), .rdata (rdata), .cyc (cyc), .busy (busy), .advance (advance),
    .kind_q (kind_q), .fixed_q (fixed_q), .ptr_q (ptr_q), .lpc_q (lpc_q),
    .idx_q (idx_q), .step_q (step_q), .lo_q (lo_q), .rd_q (rd_q)
  );

  assign bus_valid   = busy && cyc.vld;
  assign bus_addr    = cyc.addr;
  assign bus_write   = busy && cyc.vld && cyc.wr;
  assign bus_wdata   = cyc.wnew ? rmw_result : rd_q;
  assign rmw_operand = rd_q;
  assign done        = advance && cyc.last;
  assign done_addr   = (kind_q == K_JMP) ? {rdata, lo_q} : ea;

  a_r2_legacy_ptr_page: assert property (@(posedge clk) disable iff (!rst_n)
    done && kind_q == K_JMP && !fixed_q |-> bus_addr[AW-1:PW] == ptr_q[AW-1:PW]);

  a_r5_dummy_base_page: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && kind_q == K_IDX && !fixed_q && !cyc.last |-> bus_addr[AW-1:PW] == ptr_q[AW-1:PW]);

  a_r11_done_ea_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
    done && kind_q == K_IDX |-> done_addr == bus_addr && bus_valid);

  a_r8_fixed_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_write && fixed_q |-> done || !ready);

  a_r11_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: tb/quirk_addr_seq_test.sv
module quirk_addr_seq_test;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, fixed_mode = 1'b0, ready;
  logic [1:0]  kind = 2'd0;
  logic [15:0] opnd = '0, last_pc = '0;
  logic [7:0]  index = '0, rdata, rmw_result, lfsr = 8'hB7;
  logic        bus_valid, bus_write, busy, done;
  logic [15:0] bus_addr, done_addr;
  logic [7:0]  bus_wdata, rmw_operand;
  int          rdy_mode = 0;
  int          checks = 0, errors = 0, cycles = 0;

  typedef struct {
    logic [15:0] addr;
    logic        wr;
    logic [7:0]  wd;
    logic        last;
    logic [15:0] da;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  assign rdata      = memf(bus_addr);
  assign rmw_result = rmw_operand + 8'd3;
  assign ready      = (rdy_mode == 1) ? lfsr[0] : (rdy_mode == 2) ? !bus_write : 1'b1;

  always @(posedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

  quirk_addr_seq uut (
    .clk (clk), .rst_n (rst_n), .start (start), .kind (kind), .fixed_mode (fixed_mode),
    .opnd (opnd), .last_pc (last_pc), .index (index), .ready (ready), .rdata (rdata),
    .rmw_result (rmw_result), .bus_valid (bus_valid), .bus_addr (bus_addr),
    .bus_write (bus_write), .bus_wdata (bus_wdata), .rmw_operand (rmw_operand),
    .busy (busy), .done (done), .done_addr (done_addr)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic push(input logic [15:0] a, input logic wr, input logic [7:0] wd,
                      input logic last, input logic [15:0] da, input string tag);
    exp_t e;
    e.addr = a; e.wr = wr; e.wd = wd; e.last = last; e.da = da; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: pops one expected item for each completed bus cycle
  logic        hold_pend = 1'b0;
  logic [15:0] hold_addr = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      logic cmp;
      if (hold_pend)
        chk(bus_valid && !bus_write && bus_addr == hold_addr, "R9 held read", bus_addr, hold_addr);
      hold_pend = bus_valid && !bus_write && !ready;
      hold_addr = bus_addr;
      cmp = bus_valid && (bus_write ? (!fixed_mode || ready) : ready);
      if (done && !cmp) chk(1'b0, "R11 done without cycle", 1, 0);
      if (cmp) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "unexpected bus cycle", bus_addr, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(bus_addr == e.addr, {e.tag, " addr"}, bus_addr, e.addr);
          chk(bus_write == e.wr, {e.tag, " rw"}, bus_write, e.wr);
          if (e.wr) chk(bus_wdata == e.wd, {e.tag, " wdata"}, bus_wdata, e.wd);
          chk(done == e.last, {e.tag, " R11 done"}, done, e.last);
          if (e.last) chk(done_addr == e.da, {e.tag, " R11 done_addr"}, done_addr, e.da);
        end
      end
    end
  end

  task automatic run_op(input logic [1:0] k, input logic m, input logic [15:0] p,
                        input logic [15:0] lpc, input logic [7:0] x, input int lat,
                        input logic poke, input string tag);
    logic [15:0] full, hi_a;
    logic [7:0]  old;
    int n;
    full = p + {8'h00, x};
    case (k)
      2'd0: begin
        hi_a = m ? p + 16'd1 : {p[15:8], p[7:0] + 8'd1};
        push(p, 1'b0, 8'h00, 1'b0, 16'h0, tag);
        push(hi_a, 1'b0, 8'h00, 1'b1, {memf(hi_a), memf(p)}, tag);
      end
      2'd1: begin
        if (full[15:8] != p[15:8])
          push(m ? lpc : {p[15:8], full[7:0]}, 1'b0, 8'h00, 1'b0, 16'h0, tag);
        push(full, 1'b0, 8'h00, 1'b1, full, tag);
      end
      default: begin
        old = memf(p);
        push(p, 1'b0, 8'h00, 1'b0, 16'h0, tag);
        if (m) push(p, 1'b0, 8'h00, 1'b0, 16'h0, tag);
        else   push(p, 1'b1, old, 1'b0, 16'h0, tag);
        push(p, 1'b1, old + 8'd3, 1'b1, p, tag);
      end
    endcase
    @(negedge clk);
    kind = k; fixed_mode = m; opnd = p; last_pc = lpc; index = x; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 60) begin
      if (poke && n == 1) begin start = 1'b1; opnd = 16'hDEAD; kind = 2'd1; end
      else if (poke && n == 2) start = 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    if (lat > 0) chk(n == lat, {tag, " latency"}, n, lat);
    @(negedge clk);
    chk(exp_q.size() == 0 && !busy, {tag, " sequence complete"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !bus_valid && !done, "R1 reset idle", {busy, bus_valid, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !bus_valid && !done, "R1 idle after release", {busy, bus_valid, done}, 0);

    run_op(2'd0, 1'b0, 16'h10FF, 16'h0, 8'h00, 2, 1'b0, "R2 legacy jmp wrap");
    run_op(2'd0, 1'b0, 16'h2040, 16'h0, 8'h00, 2, 1'b0, "R2 legacy jmp");
    run_op(2'd0, 1'b1, 16'h10FF, 16'h0, 8'h00, 3, 1'b0, "R3 fixed jmp cross");
    run_op(2'd0, 1'b1, 16'h2040, 16'h0, 8'h00, 2, 1'b0, "R3 fixed jmp");
    run_op(2'd1, 1'b0, 16'h3010, 16'h0802, 8'h20, 1, 1'b0, "R4 legacy idx");
    run_op(2'd1, 1'b1, 16'h3010, 16'h0802, 8'h20, 1, 1'b0, "R4 fixed idx");
    run_op(2'd1, 1'b0, 16'h30F0, 16'h0802, 8'h20, 2, 1'b0, "R5 legacy idx cross");
    run_op(2'd1, 1'b0, 16'h30FF, 16'h0802, 8'hFF, 2, 1'b0, "R5 legacy idx cross max");
    run_op(2'd1, 1'b1, 16'h30F0, 16'h0802, 8'h20, 2, 1'b0, "R6 fixed idx cross");
    run_op(2'd1, 1'b1, 16'hFFF1, 16'h1234, 8'h80, 2, 1'b0, "R6 fixed idx wrap");
    run_op(2'd2, 1'b0, 16'h4000, 16'h0, 8'h00, 3, 1'b0, "R7 legacy rmw");
    run_op(2'd2, 1'b1, 16'h4001, 16'h0, 8'h00, 3, 1'b0, "R8 fixed rmw");
    rdy_mode = 2;
    run_op(2'd2, 1'b0, 16'h4102, 16'h0, 8'h00, 3, 1'b0, "R10 legacy write ignores ready");
    rdy_mode = 1;
    for (int i = 0; i < 4; i++) begin
      run_op(2'd0, i[0], 16'h50FF + 16'(i), 16'h0, 8'h00, 0, 1'b0, "R9 stalled jmp");
      run_op(2'd1, i[0], 16'h60E0 + 16'(i), 16'h0900, 8'h30, 0, 1'b0, "R9 stalled idx");
      run_op(2'd2, i[0], 16'h7000 + 16'(i), 16'h0, 8'h00, 0, 1'b0, "R10 stalled rmw");
    end
    rdy_mode = 0;
    run_op(2'd2, 1'b0, 16'h4200, 16'h0, 8'h00, 3, 1'b1, "R12 start while busy");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule